// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers five interrupt sources and turns them into two request lines for a processor core: one for high-priority service and one for low-priority service. Three of the sources are external request pins. Each pin is edge-triggered, and a per-pin polarity bit selects whether it reacts to a rising or a falling edge. The fourth source is a one-cycle overflow pulse from a timer. The fifth is a four-bit port whose any-bit change raises a single shared event.

Each source owns a sticky flag, an enable bit and a priority bit. External pin 0 is the exception: it has no priority bit and is always treated as high priority. Both request lines are gated by a global enable. A separate wake-up output tells a sleeping core that an enabled source has fired, and this output does not depend on the global enable. Software controls the block through a small write-only register port. Through it, software sets enables, priorities and polarities, and clears flags by writing ones.

All asynchronous inputs pass through two-flop synchronisers. Edges and changes are found by comparing each synchronised value with the value from the previous cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `flags`, `irq_high`, `irq_low` and `wake` are 0, all enables and priority bits are 0, and every polarity bit is 1 (rising edge).
- R2: External pin i sets `flags[i]` (i = 0..2) on a rising edge when polarity bit i is 1 and on a falling edge when it is 0; the opposite edge leaves the flag unchanged. Polarity bits are `wr_data[2:0]` at address 2.
- R3: A set flag stays set until software writes a 1 to its bit at address 3. Bit positions at that address: 0..2 external pins, 3 timer, 4 port. Bits written as 0 leave their flags unchanged.
- R4: A flag whose enable bit is 0 still records events but drives no request. Enable bits are `wr_data[4:0]` at address 0, in the same bit order as the flags.
- R5: Priority bits are `wr_data[4:1]` at address 1 (1 = high, 0 = low). External pin 0 always requests on `irq_high`, and `wr_data[0]` at that address has no effect.
- R6: `irq_high` (`irq_low`) is 1 exactly when, one cycle earlier, the global enable (`wr_data[7]` at address 0) was 1 and some flag with its enable set had high (low) priority.
- R7: `wake` is 1 one cycle after `sleep` is 1 while a flag with its enable set is present, whatever the global enable. It is 0 when `sleep` is 0.
- R8: A one-cycle pulse on `tmr_ovf` sets `flags[3]` on the clock edge that samples it.
- R9: Any change of any bit of `port_in`, in either direction, sets `flags[4]`.
- R10: When a clear write for a flag and a new event for the same source land on the same clock edge, the flag ends up set.
- R11: An edge on an external pin appears on `flags` at the third rising clock edge after the pin changes; the request outputs follow one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 enable, 1 priority, 2 polarity, 3 flag clear) |
| wr_data | input | 8 | Register write data |
| ext_in | input | 3 | Asynchronous external request pins |
| tmr_ovf | input | 1 | Synchronous one-cycle timer wrap pulse |
| port_in | input | 4 | Asynchronous port watched for changes |
| sleep | input | 1 | Core is in sleep mode |
| flags | output | 5 | Sticky event flags (0..2 pins, 3 timer, 4 port) |
| irq_high | output | 1 | High-priority interrupt request |
| irq_low | output | 1 | Low-priority interrupt request |
| wake | output | 1 | Wake-up request for a sleeping core |

## Verification
The assertions assume that `tmr_ovf` is already synchronous to `clk`. They also assume that all inputs, including `tmr_ovf` and `port_in`, are quiet while reset is held, so no event is pending when reset falls. The directed stimulus respects both assumptions. It drives every input at the falling clock edge, keeps `tmr_ovf` to single-cycle pulses, and returns all inputs to 0 before reset and between scenarios. Pins and port bits are held stable for several cycles after each change, so each change is captured by the synchronisers as exactly one event.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_ENABLE   = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRIORITY = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_POLARITY = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CLEAR    = 2'd3;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q_cur,
  output logic [WIDTH-1:0] q_prev
);
  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      hist <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      hist <= chain[STAGES-1];
    end
  end

  assign q_cur  = chain[STAGES-1];
  assign q_prev = hist;
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int LINES = 3
) (
  input  logic [LINES-1:0] pol,
  input  logic [LINES-1:0] cur,
  input  logic [LINES-1:0] prev,
  output logic [LINES-1:0] hit
);
  // R2: polarity 1 picks rising edges, polarity 0 picks falling edges
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hit[i] = pol[i] ? (cur[i] & ~prev[i]) : (~cur[i] & prev[i]);
  end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int SRCS = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SRCS-1:0] evt,
  input  logic [SRCS-1:0] clr,
  input  logic [SRCS-1:0] en,
  input  logic [SRCS-1:0] prio,
  input  logic            gie,
  input  logic            sleep,
  output logic [SRCS-1:0] flags,
  output logic            irq_high,
  output logic            irq_low,
  output logic            wake
);
  logic [SRCS-1:0] armed;
  assign armed = flags & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      irq_high <= 1'b0;
      irq_low  <= 1'b0;
      wake     <= 1'b0;
    end else begin
      flags    <= (flags & ~clr) | evt;           // event beats clear (R10)
      irq_high <= gie & |(armed & prio);
      irq_low  <= gie & |(armed & ~prio);
      wake     <= sleep & |armed;                 // global enable not used (R7)
    end
  end

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)))
    else $error("flag dropped without a clear write");

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flags & $past(evt)) == $past(evt)))
    else $error("event lost");

  assert_gie_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !gie |=> (!irq_high && !irq_low))
    else $error("request without global enable");

  assert_wake_sleep_R7: assert property (@(posedge clk) disable iff (rst)
    !sleep |=> !wake)
    else $error("wake while awake");

  assert_req_source_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_high || irq_low || wake) |-> $past(|(flags & en)))
    else $error("request without an enabled flag");
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int EXT_LINES   = 3,
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [REG_ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [EXT_LINES-1:0]         ext_in,
  input  logic                         tmr_ovf,
  input  logic [PORT_W-1:0]            port_in,
  input  logic                         sleep,
  output logic [EXT_LINES+1:0]         flags,
  output logic                         irq_high,
  output logic                         irq_low,
  output logic                         wake
);
  localparam int SRCS     = EXT_LINES + 2;
  localparam int TMR_IDX  = EXT_LINES;
  localparam int PORT_IDX = EXT_LINES + 1;
  localparam int GIE_BIT  = DATA_W - 1;

  logic [SRCS-1:0]      en_q;
  logic [SRCS-1:1]      prio_q;
  logic [EXT_LINES-1:0] pol_q;
  logic                 gie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      prio_q <= '0;
      pol_q  <= '1;
      gie_q  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_ENABLE: begin
          en_q  <= wr_data[SRCS-1:0];
          gie_q <= wr_data[GIE_BIT];
        end
        ADDR_PRIORITY: prio_q <= wr_data[SRCS-1:1];
        ADDR_POLARITY: pol_q  <= wr_data[EXT_LINES-1:0];
        default: ;
      endcase
    end
  end

  logic [SRCS-1:0] clr;
  assign clr = (wr_en && wr_addr == ADDR_CLEAR) ? wr_data[SRCS-1:0] : '0;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[GIE_BIT-1:SRCS], wr_data[0]};

  logic [EXT_LINES-1:0] ext_cur, ext_prev, ext_hit;
  logic [PORT_W-1:0]    port_cur, port_prev;

  irqc_sync #(.WIDTH(EXT_LINES), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .d(ext_in), .q_cur(ext_cur), .q_prev(ext_prev));

  irqc_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
    .clk(clk), .rst(rst), .d(port_in), .q_cur(port_cur), .q_prev(port_prev));

  irqc_edge #(.LINES(EXT_LINES)) u_edge (
    .pol(pol_q), .cur(ext_cur), .prev(ext_prev), .hit(ext_hit));

  logic [SRCS-1:0] evt;
  assign evt[EXT_LINES-1:0] = ext_hit;
  assign evt[TMR_IDX]       = tmr_ovf;
  assign evt[PORT_IDX]      = |(port_cur ^ port_prev);

  logic [SRCS-1:0] prio_eff;
  assign prio_eff = {prio_q, 1'b1};   // pin 0 is always high priority (R5)

  irqc_flags #(.SRCS(SRCS)) u_flags (
    .clk(clk), .rst(rst), .evt(evt), .clr(clr), .en(en_q), .prio(prio_eff),
    .gie(gie_q), .sleep(sleep), .flags(flags),
    .irq_high(irq_high), .irq_low(irq_low), .wake(wake));

  assert_pin0_never_low_R5: assert property (@(posedge clk) disable iff (rst)
    irq_low |-> $past(|(flags[SRCS-1:1] & en_q[SRCS-1:1])))
    else $error("low request with only pin 0 pending");
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] ext_in = '0;
  logic       tmr_ovf = 1'b0;
  logic [3:0] port_in = '0;
  logic       sleep = 1'b0;
  logic [4:0] flags;
  logic       irq_high, irq_low, wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_in(ext_in), .tmr_ovf(tmr_ovf), .port_in(port_in), .sleep(sleep),
    .flags(flags), .irq_high(irq_high), .irq_low(irq_low), .wake(wake));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic init_state;
    ext_in = '0; port_in = '0; tmr_ovf = 1'b0; sleep = 1'b0;
    tick(5);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h07); wr(2'd3, 8'h1F);
    tick(2);
  endtask

  task automatic t_reset;
    tick(3); rst = 1'b0; tick(1);
    chk("R1 flags after reset", flags, 0);
    chk("R1 irq_high after reset", irq_high, 0);
    chk("R1 irq_low after reset", irq_low, 0);
    chk("R1 wake after reset", wake, 0);
    ext_in[0] = 1'b1;
    tick(2); chk("R11 flag not yet at edge 2", flags[0], 0);
    tick(1); chk("R11 R1 rising default sets flag at edge 3", flags[0], 1);
    chk("R1 no request with enables cleared", irq_high, 0);
    wr(2'd0, 8'h81); tick(1);
    chk("R5 pin0 high with priority reg 0", irq_high, 1);
    chk("R5 pin0 not on low line", irq_low, 0);
  endtask

  task automatic t_polarity;
    init_state;
    wr(2'd2, 8'h05);
    ext_in[1] = 1'b1; tick(5);
    chk("R2 rising ignored on falling pin", flags[1], 0);
    ext_in[1] = 1'b0; tick(5);
    chk("R2 falling sets flag", flags[1], 1);
    ext_in[2] = 1'b1; tick(5);
    chk("R2 rising pin sets flag", flags[2], 1);
    wr(2'd3, 8'h04); tick(1);
    ext_in[2] = 1'b0; tick(5);
    chk("R2 falling ignored on rising pin", flags[2], 0);
  endtask

  task automatic t_sticky;
    init_state;
    ext_in[1:0] = 2'b11; tick(25);
    chk("R3 flags held", flags, 3);
    wr(2'd3, 8'h02);
    chk("R3 only written bit cleared", flags, 1);
  endtask

  task automatic t_enable;
    init_state;
    wr(2'd0, 8'h80);
    ext_in[2:1] = 2'b11; tick(5);
    chk("R4 disabled flags recorded", flags, 6);
    chk("R4 disabled no request", irq_low, 0);
    wr(2'd0, 8'h82); tick(1);
    chk("R4 enabled low request", irq_low, 1);
    wr(2'd3, 8'h02); tick(1);
    chk("R4 request drops after clear", irq_low, 0);
  endtask

  task automatic t_priority;
    init_state;
    wr(2'd0, 8'h84);
    ext_in[2] = 1'b1; tick(5);
    chk("R5 prio 0 on low", irq_low, 1);
    chk("R5 prio 0 not high", irq_high, 0);
    wr(2'd1, 8'h04); tick(1);
    chk("R5 prio 1 on high", irq_high, 1);
    chk("R5 prio 1 not low", irq_low, 0);
    wr(2'd3, 8'h1F);
    wr(2'd0, 8'h81); wr(2'd1, 8'h01);
    ext_in[0] = 1'b1; tick(5);
    chk("R5 bit0 of priority ignored, low", irq_low, 0);
    chk("R5 pin0 still high", irq_high, 1);
  endtask

  task automatic t_gie;
    init_state;
    wr(2'd0, 8'h01);
    ext_in[0] = 1'b1; tick(5);
    chk("R6 no request without global enable", irq_high, 0);
    wr(2'd0, 8'h81); tick(1);
    chk("R6 request with global enable", irq_high, 1);
  endtask

  task automatic t_wake;
    init_state;
    wr(2'd0, 8'h01);
    sleep = 1'b1;
    ext_in[0] = 1'b1; tick(5);
    chk("R7 wake with gie off", wake, 1);
    chk("R7 no irq with gie off", irq_high, 0);
    sleep = 1'b0; tick(1);
    chk("R7 wake clear when awake", wake, 0);
    init_state;
    sleep = 1'b1;
    ext_in[1] = 1'b1; tick(5);
    chk("R7 disabled source no wake", wake, 0);
    sleep = 1'b0;
  endtask

  task automatic t_timer;
    init_state;
    wr(2'd0, 8'h88); wr(2'd1, 8'h08);
    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
    chk("R8 timer flag set next edge", flags[3], 1);
    tick(1);
    chk("R8 timer high request", irq_high, 1);
  endtask

  task automatic t_port;
    init_state;
    port_in = 4'b0100; tick(5);
    chk("R9 port rise sets flag", flags[4], 1);
    wr(2'd3, 8'h10); tick(5);
    chk("R9 no change no flag", flags[4], 0);
    port_in = 4'b0000; tick(5);
    chk("R9 port fall sets flag", flags[4], 1);
  endtask

  task automatic t_race;
    init_state;
    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
    tmr_ovf = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h08;
    tick(1);
    tmr_ovf = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R10 event beats clear", flags[3], 1);
    wr(2'd3, 8'h08);
    chk("R10 plain clear works", flags[3], 0);
  endtask

  initial begin
    t_reset;
    t_polarity;
    t_sticky;
    t_enable;
    t_priority;
    t_gie;
    t_wake;
    t_timer;
    t_port;
    t_race;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule